// File: doc/BRIEF.md
# External Bus Read Sequencer

This block performs single read transfers on an asynchronous external parallel bus. An internal requester raises a one-cycle request with an address. While the block is idle, it latches the three phase lengths and the ready controls. It then drives chip-select, read strobe and address through three phases: setup, strobe and hold. It returns the captured word with a one-cycle completion pulse. One timing-clock cycle equals one cycle of `clk`.

The strobe phase can be extended by a ready input. The first check of ready happens only once the setup and strobe counts have both run out. After that, ready is re-checked every cycle until it is seen high. Ready can be used as a signal already aligned to `clk`, or it can be passed through a flop chain first when it comes from an unrelated clock domain. Between transfers the address pins keep the last address issued, but bit 0 is forced high.

Top module: `ext_rd_seq`

## Requirements
- R1: After a synchronous reset (including one applied in the middle of a transfer), `bus_cs_n` and `bus_rd_n` are 1, `rd_done` is 0, `rd_data` is 0 and `bus_addr` is all zeros except bit 0, which is 1.
- R2: A request seen at a clock edge while idle drives `bus_cs_n` low and `bus_addr` to `rq_addr` from that edge onward (cycle index 0 of the transfer).
- R3: `bus_rd_n` goes low at cycle index Ls, where Ls is the setup count; the strobe is never low while chip-select is high.
- R4: With ready checking disabled (`rdy_use`=0), the strobe stays low for exactly St cycles (the strobe count), whatever the ready pin does.
- R5: With ready checking enabled in aligned mode (`rdy_cdc`=0), ready is checked at the edge Ls+St+n-1 for check n = 1, 2, …; a low value keeps the strobe low one more cycle, and the strobe rises at the first edge where ready is high.
- R6: In cross-domain mode (`rdy_cdc`=1) ready passes through a two-flop chain, so a rise of the pin seen at edge p becomes usable at edge p+2.
- R7: `rd_data` takes the value on `bus_din` at the edge where the strobe rises, and it does not change at any other edge.
- R8: The hold phase lasts Hd cycles (the hold count) after the strobe rises; at its end `bus_cs_n` rises and `rd_done` is 1 for exactly one cycle.
- R9: While no transfer is in progress, `bus_addr` keeps the last address issued, with bit 0 at 1.
- R10: A request raised during a transfer is ignored: the address and the timing of the current transfer do not change.
- R11: A setup, strobe or hold count of 0 behaves as a count of 1.
- R12: Phase counts, `rdy_use` and `rdy_cdc` are latched when the request is accepted; changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timing clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Read request, sampled only while idle |
| rq_addr | input | AW | Address of the requested read |
| cfg_setup | input | CW | Setup phase length in cycles (0 means 1) |
| cfg_strobe | input | CW | Strobe phase length in cycles (0 means 1) |
| cfg_hold | input | CW | Hold phase length in cycles (0 means 1) |
| rdy_use | input | 1 | 1: extend the strobe with the ready pin |
| rdy_cdc | input | 1 | 1: pass ready through the synchronizer chain |
| bus_rdy | input | 1 | Ready pin from the external device |
| bus_din | input | DW | Read data pins |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | AW | Address pins |
| rd_data | output | DW | Captured read data |
| rd_done | output | 1 | One-cycle pulse at end of transfer |

## Verification
The hardest case to reach is a cross-domain ready that rises during the stretch. The ready pin has to be low before the chain reaches its first check, and the strobe then has to stay low for two extra cycles after the pin rises. The bench handles this by computing the pin level for every cycle of the transfer from its position relative to Ls+St. It pulls ready low already at the accept edge and raises it at the planned edge. At the same time it puts the expected word on the data pins only in the cycle of the predicted strobe rise, so a capture that comes one cycle early or late shows up as wrong data.

// File: rtl/ext_rd_pkg.sv
package ext_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;
endpackage

// File: rtl/ext_rd_rdy_sync.sv
module ext_rd_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_rdy,
  input  logic cdc_sel,
  output logic rdy_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin_rdy;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rdy_out = cdc_sel ? chain[STAGES-1] : pin_rdy;

  // R6: the synchronized output follows the pin with one cycle per stage of delay
  p_chain_step_r6: assert property (@(posedge clk) disable iff (rst)
    chain[0] |=> (STAGES == 1) || chain[1]);
endmodule

// File: rtl/ext_rd_phase_cnt.sv
module ext_rd_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          expired
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= (load_len == '0) ? '0 : load_len - 1'b1;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R11: once expired and not reloaded, the counter stays expired (no wrap)
  p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);
endmodule

// File: rtl/ext_rd_seq.sv
module ext_rd_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rq_valid,
  input  logic [AW-1:0] rq_addr,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic          rdy_use,
  input  logic          rdy_cdc,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_din,
  output logic          bus_cs_n,
  output logic          bus_rd_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_done
);
  import ext_rd_pkg::*;

  localparam logic [AW-1:0] ADDR_RST = AW'(1);

  phase_t        phase;
  logic [CW-1:0] strobe_q, hold_q;
  logic          use_q, cdc_q;
  logic          rdy_s;
  logic          expired;
  logic          cnt_load;
  logic [CW-1:0] cnt_len;
  logic          accept, setup_end, strobe_end, hold_end;

  ext_rd_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_rdy(bus_rdy),
    .cdc_sel(cdc_q),
    .rdy_out(rdy_s)
  );

  ext_rd_phase_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_len(cnt_len),
    .expired (expired)
  );

  always_comb begin
    accept     = (phase == PH_IDLE) && rq_valid;
    setup_end  = (phase == PH_SETUP) && expired;
    strobe_end = (phase == PH_STROBE) && expired && (!use_q || rdy_s);
    hold_end   = (phase == PH_HOLD) && expired;
    cnt_load   = accept || setup_end || strobe_end;
    if (accept)         cnt_len = cfg_setup;
    else if (setup_end) cnt_len = strobe_q;
    else                cnt_len = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      strobe_q <= '0;
      hold_q   <= '0;
      use_q    <= 1'b0;
      cdc_q    <= 1'b0;
      bus_cs_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_addr <= ADDR_RST;
      rd_data  <= '0;
      rd_done  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_SETUP;
          strobe_q <= cfg_strobe;
          hold_q   <= cfg_hold;
          use_q    <= rdy_use;
          cdc_q    <= rdy_cdc;
          bus_cs_n <= 1'b0;
          bus_addr <= rq_addr;
        end
        PH_SETUP: if (setup_end) begin
          phase    <= PH_STROBE;
          bus_rd_n <= 1'b0;
        end
        PH_STROBE: if (strobe_end) begin
          phase    <= PH_HOLD;
          bus_rd_n <= 1'b1;
          rd_data  <= bus_din;
        end
        PH_HOLD: if (hold_end) begin
          phase       <= PH_IDLE;
          bus_cs_n    <= 1'b1;
          rd_done     <= 1'b1;
          bus_addr[0] <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: strobe only inside chip-select
  p_rd_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_cs_n);
  // R5: an expired strobe phase with ready low keeps the strobe low
  p_wait_low_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && expired && use_q && !rdy_s) |=> !bus_rd_n);
  // R7: captured data only moves when the strobe rises
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$rose(bus_rd_n) |-> $stable(rd_data));
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
  // R8: chip-select release coincides with completion
  p_cs_rise_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> rd_done);
  // R9: idle address has bit 0 high
  p_idle_a0_r9: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n |-> bus_addr[0]);
  // R10: address is frozen during a transfer
  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
endmodule

// File: tb/sim_ext_rd_seq.sv
module sim_ext_rd_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  typedef struct packed {
    logic [3:0]  ls;
    logic [3:0]  st;
    logic [3:0]  hd;
    logic        en;
    logic        cdc;
    logic [3:0]  w;
    logic [15:0] ad;
    logic [15:0] dt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  4'd1,  4'd1,  1'b0, 1'b0, 4'd3, 16'h1234, 16'hBEEF},
    '{4'd2,  4'd3,  4'd2,  1'b1, 1'b0, 4'd0, 16'h2000, 16'h1111},
    '{4'd1,  4'd2,  4'd1,  1'b1, 1'b0, 4'd4, 16'h00FE, 16'h2222},
    '{4'd3,  4'd1,  4'd2,  1'b1, 1'b1, 4'd3, 16'h0F0E, 16'h3333},
    '{4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 4'd0, 16'hAAAA, 16'h4444},
    '{4'd15, 4'd15, 4'd15, 1'b1, 1'b1, 4'd0, 16'h5555, 16'h5A5A},
    '{4'd2,  4'd2,  4'd3,  1'b1, 1'b1, 4'd1, 16'h8000, 16'h6666},
    '{4'd0,  4'd1,  4'd0,  1'b1, 1'b0, 4'd1, 16'h7FFE, 16'h7777}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rq_valid = 1'b0;
  logic [AW-1:0] rq_addr = '0;
  logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic          rdy_use = 1'b0, rdy_cdc = 1'b0, bus_rdy = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic          bus_cs_n, bus_rd_n, rd_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ext_rd_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_addr(rq_addr),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .rdy_use(rdy_use), .rdy_cdc(rdy_cdc), .bus_rdy(bus_rdy), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
    .rd_data(rd_data), .rd_done(rd_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [3:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  task automatic chk_reset_state(input string tag);
    chk(bus_cs_n == 1'b1, {tag, " cs"}, 32'(bus_cs_n), 1);
    chk(bus_rd_n == 1'b1, {tag, " rd"}, 32'(bus_rd_n), 1);
    chk(rd_done == 1'b0, {tag, " done"}, 32'(rd_done), 0);
    chk(bus_addr == 16'h0001, {tag, " addr"}, 32'(bus_addr), 32'h1);
    chk(rd_data == '0, {tag, " data"}, 32'(rd_data), 0);
  endtask

  // One full transfer; each cycle index m is checked after edge m.
  task automatic run_vec(input vec_t v);
    int lf, af, tf, e, last;
    lf = eff(v.ls); af = eff(v.st); tf = eff(v.hd);
    if (!v.en)            e = lf + af;
    else if (!v.cdc)      e = lf + af + int'(v.w);
    else if (v.w == 0)    e = lf + af;
    else                  e = lf + af + int'(v.w) + 2;
    last = e + tf;
    // inputs for edge 0
    rq_valid = 1'b1; rq_addr = v.ad;
    cfg_setup = v.ls; cfg_strobe = v.st; cfg_hold = v.hd;
    rdy_use = v.en; rdy_cdc = v.cdc;
    bus_rdy = (v.w == 0) ? 1'b1 : 1'b0;
    bus_din = (e == 0) ? v.dt : ~v.dt;
    for (int m = 0; m <= last + 1; m++) begin
      @(posedge clk);
      @(negedge clk);
      // R2 / R8 chip-select window
      chk(bus_cs_n == ((m < last) ? 1'b0 : 1'b1), "R2/R8 cs window",
          32'(bus_cs_n), 32'((m < last) ? 0 : 1));
      // R3 / R4 / R5 / R6 strobe window
      chk(bus_rd_n == ((m >= lf && m < e) ? 1'b0 : 1'b1), "R3-5 R6 rd window",
          32'(bus_rd_n), 32'((m >= lf && m < e) ? 0 : 1));
      // R8 done pulse
      chk(rd_done == (m == last), "R8 done", 32'(rd_done), 32'(m == last));
      // R9 / R10 address
      if (m < last)
        chk(bus_addr == v.ad, "R10 addr in access", 32'(bus_addr), 32'(v.ad));
      else
        chk(bus_addr == (v.ad | 16'h1), "R9 idle addr", 32'(bus_addr),
            32'(v.ad | 16'h1));
      // R7 captured data
      if (m >= e)
        chk(rd_data == v.dt, "R7 data", 32'(rd_data), 32'(v.dt));
      // inputs for edge m+1; R10 stray request, R12 altered config
      rq_valid = (m + 1 == 1);
      rq_addr = ~v.ad;
      cfg_setup = ~v.ls; cfg_strobe = ~v.st; cfg_hold = ~v.hd;
      rdy_use = ~v.en; rdy_cdc = ~v.cdc;
      bus_rdy = (v.w == 0) ? 1'b1 : ((m + 1) >= lf + af + int'(v.w));
      bus_din = ((m + 1) == e) ? v.dt : ~v.dt;
    end
    rq_valid = 1'b0;
    bus_rdy = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_reset_state("R1 reset");
    // R4 R5 R6 R7 R8 R9 R10 R11 R12 by the table walk
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R1: reset in the middle of a transfer
    rq_valid = 1'b1; rq_addr = 16'h4242;
    cfg_setup = 4'd5; cfg_strobe = 4'd5; cfg_hold = 4'd5;
    rdy_use = 1'b0; rdy_cdc = 1'b0;
    @(posedge clk); @(negedge clk);
    rq_valid = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(bus_rd_n == 1'b0, "R3 strobe before reset", 32'(bus_rd_n), 0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_reset_state("R1 mid reset");
    // R11/R12 again after reset: one more transfer with zero counts
    run_vec('{4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 4'd2, 16'h0F00, 16'h0BAD});
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule